// File: doc/BRIEF.md
# Virtual-to-Physical Translation Unit with True-LRU Frame Eviction

This block turns a 12-bit virtual address into an 11-bit physical address. Pages are 256 bytes, so 16 virtual pages map onto 8 physical frames. Each request first looks in a small direct-mapped translation cache of four slots. If that misses, it reads a 16-entry page table. If the page table has no valid mapping, the access is a page fault, and the block resolves it entirely in hardware.

On a fault the block takes the frame that has gone unused the longest. It removes every mapping that pointed at that frame, from both the page table and the translation cache. It then maps the requested page onto the frame and completes the access in the same cycle. Moving data to and from backing store is left to the surrounding system.

The block keeps a full recency order over all eight frames, so the frame it evicts is the exact least-recently-used one. Before translations begin, the caller loads the translation cache, the page table and the recency order through a configuration port.

Top module: `xlate_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `rsp_valid` is 0 and `rsp_kind` is 0.
- R2: A request accepted at a clock edge produces its response at that same edge. The response is visible for the following cycle, and `rsp_paddr` = {frame number, `req_vaddr[7:0]`}, with the offset passed through unchanged.
- R3: The cache slot is `vpn[1:0]` and the stored tag is `vpn[3:2]`, where `vpn = req_vaddr[11:8]`. If the slot is valid and its tag matches, the response is a hit (`rsp_kind` = 1) and uses the slot's frame number.
- R4: On a cache miss with a valid page-table entry, the response is a miss (`rsp_kind` = 2) and uses the page table's frame number. The indexed cache slot is overwritten with this mapping, so an immediate repeat of the same page is a hit.
- R5: On a cache miss with an invalid page-table entry, the response is a fault (`rsp_kind` = 3). The frame used is the least recently used frame.
- R6: On a fault, two things happen before the new mapping is written:
  - every page-table entry that mapped the victim frame is invalidated;
  - every cache slot that held the victim frame is invalidated.

  The requested page is then mapped to the victim frame, both in the page table and in its cache slot.
- R7: Every accepted access makes its frame the most recent. The frames that were more recent than it each move one place toward least recent, and the order of the other frames is unchanged.
- R8: Configuration uses `cfg_we`, `cfg_sel`, `cfg_idx` and `cfg_data`, and takes priority over requests. While `cfg_we` is 1, a request is ignored: no response is produced and no state changes apart from the configured entry. The encodings are:

  | `cfg_sel` | Target | `cfg_idx` | `cfg_data` |
  |---|---|---|---|
  | 0 | cache slot | `cfg_idx[1:0]` selects the slot | {valid, tag[1:0], frame[2:0]} |
  | 1 | page-table entry | `cfg_idx[3:0]` selects the entry | valid in bit 5, frame in bits 2:0 |
  | 2 | recency position | `cfg_idx[2:0]` selects the position (0 = most recent, 7 = least recent) | frame in bits 2:0 |

- R9: Each response carries exactly one class, encoded as hit = 1, miss = 2 or fault = 3. When there is no response, `rsp_kind` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 cache slot, 1 page table, 2 recency position |
| cfg_idx | input | 4 | Slot, entry or position index |
| cfg_data | input | 6 | {valid, tag, frame} configuration value |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 12 | Virtual address |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 11 | Physical address |
| rsp_kind | output | 2 | Access class: 0 none, 1 hit, 2 miss, 3 fault |

## Verification
Every result is registered exactly once, so a response is due one clock after its request is sampled. A configuration write produces no response in that same following cycle. The bench drives inputs on the falling edge and applies each request to its behavioural reference model in that same cycle. It then compares `rsp_valid`, `rsp_kind` and `rsp_paddr` on the next falling edge.

Back-to-back requests are issued without gaps. This makes the refill of the translation cache, the invalidations after a fault and the recency update visible to the very next access. A pseudo-random sequence then keeps comparing against the model on every cycle, including the idle ones.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_BITS  = 12;
  localparam int PA_BITS  = 11;
  localparam int OFF_BITS = 8;
  localparam int TLB_SLOTS = 4;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_HIT   = 2'd1,
    KIND_MISS  = 2'd2,
    KIND_FAULT = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    SEL_TLB  = 2'd0,
    SEL_PT   = 2'd1,
    SEL_REC  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 2,
  parameter int PPN_W = 3,
  localparam int N = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             inv_en,
  input  logic [PPN_W-1:0] inv_ppn
);
  logic             ent_v [N];
  logic [TAG_W-1:0] ent_t [N];
  logic [PPN_W-1:0] ent_p [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic             v_q, v_d;
    logic [TAG_W-1:0] t_q, t_d;
    logic [PPN_W-1:0] p_q, p_d;
    logic             wr_me, kill_me, en;

    assign wr_me   = wr_en && (wr_idx == IDX_W'(i));
    assign kill_me = inv_en && v_q && (p_q == inv_ppn);
    assign en      = wr_me || kill_me;

    // a write to this slot wins over an invalidation in the same cycle
    always_comb begin
      v_d = v_q;
      t_d = t_q;
      p_d = p_q;
      if (kill_me) v_d = 1'b0;
      if (wr_me) begin
        v_d = wr_valid;
        t_d = wr_tag;
        p_d = wr_ppn;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        p_q <= '0;
      end else if (en) begin
        v_q <= v_d;
        t_q <= t_d;
        p_q <= p_d;
      end
    end

    assign ent_v[i] = v_q;
    assign ent_t[i] = t_q;
    assign ent_p[i] = p_q;
  end

  assign lk_hit = ent_v[lk_idx] && (ent_t[lk_idx] == lk_tag);
  assign lk_ppn = ent_p[lk_idx];
endmodule

// File: rtl/xlate_ptab.sv
module xlate_ptab #(
  parameter int VPN_W = 4,
  parameter int PPN_W = 3,
  localparam int N = 1 << VPN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_valid,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_valid,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             inv_en,
  input  logic [PPN_W-1:0] inv_ppn
);
  logic             ent_v [N];
  logic [PPN_W-1:0] ent_p [N];

  for (genvar i = 0; i < N; i++) begin : g_pte
    logic             v_q, v_d;
    logic [PPN_W-1:0] p_q, p_d;
    logic             wr_me, kill_me, en;

    assign wr_me   = wr_en && (wr_vpn == VPN_W'(i));
    assign kill_me = inv_en && v_q && (p_q == inv_ppn);
    assign en      = wr_me || kill_me;

    always_comb begin
      v_d = v_q;
      p_d = p_q;
      if (kill_me) v_d = 1'b0;
      if (wr_me) begin
        v_d = wr_valid;
        p_d = wr_ppn;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        p_q <= '0;
      end else if (en) begin
        v_q <= v_d;
        p_q <= p_d;
      end
    end

    assign ent_v[i] = v_q;
    assign ent_p[i] = p_q;
  end

  assign lk_valid = ent_v[lk_vpn];
  assign lk_ppn   = ent_p[lk_vpn];
endmodule

// File: rtl/xlate_recency.sv
module xlate_recency #(
  parameter int PPN_W = 3,
  localparam int N = 1 << PPN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [PPN_W-1:0] touch_frm,
  input  logic             cfg_en,
  input  logic [PPN_W-1:0] cfg_pos,
  input  logic [PPN_W-1:0] cfg_frm,
  output logic [PPN_W-1:0] victim
);
  // position 0 is most recent, position N-1 least recent
  logic [PPN_W-1:0] ord_q [N];
  logic [PPN_W-1:0] ord_d [N];
  logic [N-1:0]     match;
  logic [N-1:0]     at_or_below;
  logic             en;

  for (genvar i = 0; i < N; i++) begin : g_match
    assign match[i] = (ord_q[i] == touch_frm);
  end

  // at_or_below[i]: the touched frame sits at position i or further back
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      acc            = acc | match[i];
      at_or_below[i] = acc;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) ord_d[i] = ord_q[i];
    if (cfg_en) begin
      ord_d[cfg_pos] = cfg_frm;
    end else if (touch_en) begin
      ord_d[0] = touch_frm;
      for (int i = 1; i < N; i++) begin
        if (at_or_below[i]) ord_d[i] = ord_q[i-1];
      end
    end
  end

  assign en = cfg_en || touch_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ord_q[i] <= PPN_W'(i);
    end else if (en) begin
      for (int i = 0; i < N; i++) ord_q[i] <= ord_d[i];
    end
  end

  assign victim = ord_q[N-1];
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit
  import xlate_pkg::*;
#(
  parameter int VA_W  = VA_BITS,
  parameter int PA_W  = PA_BITS,
  parameter int OFF_W = OFF_BITS,
  parameter int TLB_N = TLB_SLOTS,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int IDX_W = $clog2(TLB_N),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int CFG_W = 1 + TAG_W + PPN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [VPN_W-1:0] cfg_idx,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_kind
);
  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] off;
  logic             go;

  logic             tlb_hit;
  logic [PPN_W-1:0] tlb_ppn;
  logic             pt_valid;
  logic [PPN_W-1:0] pt_ppn;
  logic [PPN_W-1:0] victim;

  kind_e            kind_c;
  logic [PPN_W-1:0] ppn_c;
  logic             is_fault;

  logic             cfg_tlb, cfg_pt, cfg_rec;
  logic             tlb_wr, pt_wr;
  logic [IDX_W-1:0] tlb_wr_idx;
  logic [VPN_W-1:0] pt_wr_vpn;
  logic             wr_valid;
  logic [TAG_W-1:0] tlb_wr_tag;
  logic [PPN_W-1:0] wr_ppn;

  logic             rsp_valid_q, rsp_valid_d;
  logic [PA_W-1:0]  rsp_paddr_q, rsp_paddr_d;
  kind_e            rsp_kind_q, rsp_kind_d;

  assign vpn = req_vaddr[VA_W-1:OFF_W];
  assign off = req_vaddr[OFF_W-1:0];
  assign go  = req_valid && !cfg_we;

  assign cfg_tlb = cfg_we && (cfg_sel == SEL_TLB);
  assign cfg_pt  = cfg_we && (cfg_sel == SEL_PT);
  assign cfg_rec = cfg_we && (cfg_sel == SEL_REC);

  // classification: cache, then page table, then fault
  always_comb begin
    kind_c = KIND_NONE;
    ppn_c  = tlb_ppn;
    if (go) begin
      if (tlb_hit) begin
        kind_c = KIND_HIT;
        ppn_c  = tlb_ppn;
      end else if (pt_valid) begin
        kind_c = KIND_MISS;
        ppn_c  = pt_ppn;
      end else begin
        kind_c = KIND_FAULT;
        ppn_c  = victim;
      end
    end
  end

  assign is_fault = (kind_c == KIND_FAULT);

  // write ports: configuration, else refill or install
  always_comb begin
    tlb_wr     = 1'b0;
    pt_wr      = 1'b0;
    tlb_wr_idx = vpn[IDX_W-1:0];
    pt_wr_vpn  = vpn;
    wr_valid   = 1'b1;
    tlb_wr_tag = vpn[VPN_W-1:IDX_W];
    wr_ppn     = ppn_c;
    if (cfg_we) begin
      tlb_wr     = cfg_tlb;
      pt_wr      = cfg_pt;
      tlb_wr_idx = cfg_idx[IDX_W-1:0];
      pt_wr_vpn  = cfg_idx;
      wr_valid   = cfg_data[CFG_W-1];
      tlb_wr_tag = cfg_data[PPN_W +: TAG_W];
      wr_ppn     = cfg_data[PPN_W-1:0];
    end else if (go) begin
      tlb_wr = !tlb_hit;
      pt_wr  = is_fault;
    end
  end

  xlate_tlb #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (vpn[IDX_W-1:0]),
    .lk_tag   (vpn[VPN_W-1:IDX_W]),
    .lk_hit   (tlb_hit),
    .lk_ppn   (tlb_ppn),
    .wr_en    (tlb_wr),
    .wr_idx   (tlb_wr_idx),
    .wr_valid (wr_valid),
    .wr_tag   (tlb_wr_tag),
    .wr_ppn   (wr_ppn),
    .inv_en   (is_fault),
    .inv_ppn  (victim)
  );

  xlate_ptab #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_ptab (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vpn   (vpn),
    .lk_valid (pt_valid),
    .lk_ppn   (pt_ppn),
    .wr_en    (pt_wr),
    .wr_vpn   (pt_wr_vpn),
    .wr_valid (wr_valid),
    .wr_ppn   (wr_ppn),
    .inv_en   (is_fault),
    .inv_ppn  (victim)
  );

  xlate_recency #(.PPN_W(PPN_W)) u_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (go),
    .touch_frm (ppn_c),
    .cfg_en    (cfg_rec),
    .cfg_pos   (cfg_idx[PPN_W-1:0]),
    .cfg_frm   (cfg_data[PPN_W-1:0]),
    .victim    (victim)
  );

  always_comb begin
    rsp_valid_d = go;
    rsp_kind_d  = kind_c;
    rsp_paddr_d = {ppn_c, off};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_kind_q  <= KIND_NONE;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_kind_q  <= rsp_kind_d;
      rsp_paddr_q <= rsp_paddr_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_kind  = rsp_kind_q;
  assign rsp_paddr = rsp_paddr_q;
endmodule

// File: rtl/xlate_checks.sv
module xlate_checks #(
  parameter int VA_W  = 12,
  parameter int PA_W  = 11,
  parameter int OFF_W = 8,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_kind
);
  logic             go;
  logic             prev_go_q;
  logic [VPN_W-1:0] prev_vpn_q;
  logic             same_q;

  assign go = req_valid && !cfg_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_go_q  <= 1'b0;
      prev_vpn_q <= '0;
      same_q     <= 1'b0;
    end else begin
      prev_go_q  <= go;
      prev_vpn_q <= req_vaddr[VA_W-1:OFF_W];
      same_q     <= go && prev_go_q && (req_vaddr[VA_W-1:OFF_W] == prev_vpn_q);
    end
  end

  assert_resp_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> rsp_valid && (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  assert_cfg_blocks_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !rsp_valid);

  assert_class_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind != 2'd0));

  assert_class_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_kind == 2'd0));

  assert_repeat_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    same_q |-> (rsp_kind == 2'd1) &&
               (rsp_paddr[PA_W-1:OFF_W] == $past(rsp_paddr[PA_W-1:OFF_W])));

  assert_victim_not_mru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_kind == 2'd3) && $past(rsp_valid)) |->
      (rsp_paddr[PA_W-1:OFF_W] != $past(rsp_paddr[PA_W-1:OFF_W])));

  initial begin
    assert_ppn_fits_R7: assert (PPN_W >= 1 && PPN_W < VPN_W + 1);
  end
endmodule

bind xlate_unit xlate_checks #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .req_valid (req_valid),
  .req_vaddr (req_vaddr),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_kind  (rsp_kind)
);

// File: tb/test_xlate_unit.sv
`timescale 1ns/1ps
module test_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [3:0]  cfg_idx;
  logic [5:0]  cfg_data;
  logic        req_valid;
  logic [11:0] req_vaddr;
  logic        rsp_valid;
  logic [10:0] rsp_paddr;
  logic [1:0]  rsp_kind;

  always #4 clk = ~clk;

  xlate_unit i_xlate_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_idx   (cfg_idx),
    .cfg_data  (cfg_data),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_kind  (rsp_kind)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  bit m_tv [4];
  int m_tt [4];
  int m_tp [4];
  bit m_pv [16];
  int m_pp [16];
  int m_rec [$];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic void touch(input int f);
    for (int i = 0; i < m_rec.size(); i++) begin
      if (m_rec[i] == f) begin
        m_rec.delete(i);
        break;
      end
    end
    m_rec.push_front(f);
  endfunction

  task automatic model_access(input int va, output int kind, output int pa);
    int vpn, slot, tag, ppn;
    vpn  = (va >> 8) & 15;
    slot = vpn & 3;
    tag  = vpn >> 2;
    if (m_tv[slot] && m_tt[slot] == tag) begin
      kind = 1;
      ppn  = m_tp[slot];
    end else if (m_pv[vpn]) begin
      kind = 2;
      ppn  = m_pp[vpn];
      m_tv[slot] = 1; m_tt[slot] = tag; m_tp[slot] = ppn;
    end else begin
      kind = 3;
      ppn  = m_rec[m_rec.size() - 1];
      for (int j = 0; j < 16; j++) if (m_pv[j] && m_pp[j] == ppn) m_pv[j] = 0;
      for (int j = 0; j < 4; j++)  if (m_tv[j] && m_tp[j] == ppn) m_tv[j] = 0;
      m_pv[vpn] = 1; m_pp[vpn] = ppn;
      m_tv[slot] = 1; m_tt[slot] = tag; m_tp[slot] = ppn;
    end
    touch(ppn);
    pa = (ppn << 8) | (va & 255);
  endtask

  // called at a falling edge; returns at the falling edge where the response is visible
  task automatic access(input int va, input string rq);
    int k, p;
    req_valid = 1'b1;
    req_vaddr = 12'(va);
    model_access(va, k, p);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R2", int'(rsp_valid), 1);
    chk(int'(rsp_kind) == k, rq, int'(rsp_kind), k);
    chk(int'(rsp_paddr) == p, rq, int'(rsp_paddr), p);
  endtask

  task automatic idle();
    @(negedge clk);
    chk(rsp_valid == 1'b0 && rsp_kind == 2'd0, "R9", int'(rsp_kind), 0);
  endtask

  task automatic cfg(input int sel, input int idx, input int data, input bit with_req, input int va);
    cfg_we    = 1'b1;
    cfg_sel   = 2'(sel);
    cfg_idx   = 4'(idx);
    cfg_data  = 6'(data);
    req_valid = with_req;
    req_vaddr = 12'(va);
    if (sel == 0) begin
      m_tv[idx & 3] = (data >> 5) & 1;
      m_tt[idx & 3] = (data >> 3) & 3;
      m_tp[idx & 3] = data & 7;
    end else if (sel == 1) begin
      m_pv[idx & 15] = (data >> 5) & 1;
      m_pp[idx & 15] = data & 7;
    end else if (sel == 2) begin
      m_rec[idx & 7] = data & 7;
    end
    @(negedge clk);
    cfg_we    = 1'b0;
    req_valid = 1'b0;
    chk(rsp_valid == 1'b0, "R8", int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rec_init [8] = '{7, 5, 3, 4, 0, 2, 6, 1};
    int lfsr;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_idx = 4'd0; cfg_data = 6'd0;
    req_valid = 1'b0; req_vaddr = 12'd0;
    for (int i = 0; i < 4; i++) begin m_tv[i] = 0; m_tt[i] = 0; m_tp[i] = 0; end
    for (int i = 0; i < 16; i++) begin m_pv[i] = 0; m_pp[i] = 0; end
    for (int i = 0; i < 8; i++) m_rec.push_back(i);

    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0 && rsp_kind == 2'd0, "R1", int'(rsp_kind), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && rsp_kind == 2'd0, "R1", int'(rsp_kind), 0);

    // load recency order, page table and cache (R8 encodings)
    for (int i = 0; i < 8; i++) cfg(2, i, rec_init[i], 0, 0);
    cfg(1, 1, 32 | 2, 0, 0);
    cfg(1, 2, 32 | 6, 0, 0);
    cfg(1, 4, 32 | 0, 0, 0);
    cfg(1, 5, 32 | 5, 0, 0);
    cfg(1, 8, 32 | 3, 0, 0);
    cfg(1, 9, 32 | 7, 0, 0);
    cfg(1, 12, 32 | 4, 0, 0);
    cfg(1, 15, 32 | 1, 0, 0);
    cfg(0, 0, 32 | (1 << 3) | 0, 0, 0);
    cfg(0, 1, 32 | (2 << 3) | 7, 0, 0);
    cfg(0, 3, 32 | (3 << 3) | 1, 0, 0);

    access(12'h4A7, "R3");  // hit in slot 0
    access(12'h510, "R4");  // tag mismatch, page table supplies frame 5
    access(12'h5FF, "R4");  // refilled slot now hits
    access(12'h3C0, "R5");  // fault, least recent frame 1
    access(12'hF00, "R6");  // old mapping of frame 1 was removed
    access(12'h233, "R6");  // its victim's page also lost its mapping
    access(12'h9AB, "R4");
    idle();
    access(12'h700, "R7");  // fault picks frame per updated order
    access(12'h081, "R7");

    // configuration beats a request: the request must leave no trace (R8)
    cfg(1, 0, 32 | 4, 1, 12'hE00);
    idle();
    access(12'hE12, "R8");
    access(12'h0FE, "R8");

    lfsr = 12'hACE;
    for (int n = 0; n < 600; n++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 11) ^ (lfsr >> 10) ^ (lfsr >> 9) ^ (lfsr >> 3)) & 1)) & 12'hFFF;
      if ((lfsr & 15) == 5) idle();
      else access(lfsr, "R7");
    end
    idle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule